// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Gated Pull-ups and Shared Clock Pin

This block is a seven-pin general-purpose I/O port that sits on a simple register bus. It holds three registers: an output latch, a direction register, and a control register. The control register packs seven pull-up enables together with one pin-function bit. From these registers the block computes, for every pad, an output enable, an output value and a pull-up request. Reads of the data address return a mix per bit: an output bit gives back its latch, and an input bit gives back the synchronised pad level.

The topmost pin (index 6) is shared with the clock of an on-chip RC oscillator. A static strap input tells the block which oscillator is fitted:

- **RC oscillator fitted:** the pin-function bit chooses between ordinary port I/O and driving the RC clock onto the pad.
- **Crystal fitted:** the pin-function bit is ignored, and pin 6 stays an ordinary port pin.

Top module: `pio_port7`

## Requirements
- R1: After a synchronous active-high reset, the latch, direction and control registers are all zero. Every register read returns 0, `pad_pu` is 0, and with `rc_mode`=0 `pad_oe` is 0.
- R2: A write takes effect on the rising edge where `bus_wr`=1. The value of `bus_sel` picks the target: 0 = data latch, 1 = direction, 2 = control. With `bus_sel`=3 a write changes no register, and a read returns 0.
- R3: Reading `bus_sel`=1 returns the direction register in bits 6:0, whatever the pin states are. Bit 7 reads 0.
- R4: Reading `bus_sel`=2 returns the control register. Bit 7 is the pin-function bit and bits 6:0 are the pull-up enables.
- R5: Reading `bus_sel`=0 returns, for each bit whose direction bit is 1, the latch value. Bit 7 reads 0.
- R6: Reading `bus_sel`=0 returns, for each bit whose direction bit is 0, the pad level as it was before the most recent two rising edges. A change on `pin_in` shows after exactly two edges, not after one. Writes to the latch do not alter these bits.
- R7: For an ordinary pin, `pad_oe` equals its direction bit and `pad_out` equals its latch bit.
- R8: For an ordinary pin, `pad_pu` is 1 only when its pull-up enable is 1 and its direction bit is 0. With the enable at 0 the pull-up stays off in either direction.
- R9: With `rc_mode`=1 and control bit 7 = 0, pin 6 is in clock mode: `pad_oe[6]`=1, `pad_out[6]` follows `rc_clk`, and `pad_pu[6]`=0, whatever the register contents are.
- R10: With `rc_mode`=1 and control bit 7 = 1, pin 6 behaves as an ordinary pin under R7 and R8.
- R11: With `rc_mode`=0, control bit 7 has no effect, and pin 6 behaves as an ordinary pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select (0 data, 1 direction, 2 control, 3 unused) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| rc_mode | input | 1 | Static strap: 1 = RC oscillator fitted, 0 = crystal |
| rc_clk | input | 1 | RC oscillator clock to be passed to pin 6 |
| pin_in | input | 7 | Pad input levels |
| pad_oe | output | 7 | Pad output enables |
| pad_out | output | 7 | Pad output values |
| pad_pu | output | 7 | Pad pull-up requests |

## Verification
The bench builds the block with its defaults: seven pins, pin 6 as the shared pin, and a synchroniser depth of two. At this size every direction pattern (all 128) can be crossed with every pull-up pattern (all 128), so the pad gating of R7, R8 and R11 is checked in full rather than sampled. A depth of two also puts the one-edge and two-edge read boundaries of R6 within a handful of cycles. Pin 6 is then swept separately in both oscillator strap settings, with both pin-function values and both levels of the RC clock.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PORT_W = 7;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } pio_sel_e;

    typedef struct packed {
        logic              fn_io;
        logic [PORT_W-1:0] pue;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] latch;
    } pio_cfg_t;

    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] out;
        logic [PORT_W-1:0] pu;
    } pio_pad_t;

    function automatic logic [PORT_W-1:0] pu_gate(input logic [PORT_W-1:0] pue,
                                                  input logic [PORT_W-1:0] dir);
        return pue & ~dir;
    endfunction

    function automatic logic [PORT_W-1:0] pin_view(input logic [PORT_W-1:0] dir,
                                                   input logic [PORT_W-1:0] latch,
                                                   input logic [PORT_W-1:0] pin);
        return (dir & latch) | (~dir & pin);
    endfunction

endpackage

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  pio_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output pio_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (sel)
                SEL_DATA: cfg.latch <= wdata[PORT_W-1:0];
                SEL_DIR:  cfg.dir   <= wdata[PORT_W-1:0];
                SEL_CTRL: begin
                    cfg.fn_io <= wdata[DATA_W-1];
                    cfg.pue   <= wdata[PORT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (cfg == '0));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_DIR) |=> (cfg.dir == $past(wdata[PORT_W-1:0])));

    p_latch_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_DATA) |=> (cfg.latch == $past(wdata[PORT_W-1:0])));

    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel == SEL_CTRL) |=> $stable({cfg.fn_io, cfg.pue}));

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int CW = $clog2(STAGES + 1);

    logic [WIDTH-1:0] stage [STAGES];

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[k] <= '0;
                else if (k == 0) stage[k] <= d;
                else stage[k] <= stage[(k == 0) ? 0 : k-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

    logic [CW-1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != CW'(STAGES)) since_rst <= since_rst + 1'b1;
    end

    p_sync_lag_r6: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CW'(STAGES)) |-> (q == $past(d, STAGES)));

endmodule

// File: rtl/pio_padmux.sv
module pio_padmux
    import pio_pkg::*;
#(
    parameter int SHARED = PORT_W - 1
) (
    input  pio_cfg_t cfg,
    input  logic     rc_mode,
    input  logic     rc_clk,
    output pio_pad_t pad
);

    logic clk_out_mode;
    logic [PORT_W-1:0] pu_req;

    assign clk_out_mode = rc_mode & ~cfg.fn_io;
    assign pu_req       = pu_gate(cfg.pue, cfg.dir);

    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_pin
            if (i == SHARED) begin : g_shared
                always_comb begin
                    if (clk_out_mode) begin
                        pad.oe[i]  = 1'b1;
                        pad.out[i] = rc_clk;
                        pad.pu[i]  = 1'b0;
                    end else begin
                        pad.oe[i]  = cfg.dir[i];
                        pad.out[i] = cfg.latch[i];
                        pad.pu[i]  = pu_req[i];
                    end
                end
            end else begin : g_plain
                assign pad.oe[i]  = cfg.dir[i];
                assign pad.out[i] = cfg.latch[i];
                assign pad.pu[i]  = pu_req[i];
            end
        end
    endgenerate

    always_comb begin
        p_pu_out_excl_r8: assert ((pad.pu & pad.oe) == '0);
    end

endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
(
    input  pio_sel_e          sel,
    input  pio_cfg_t          cfg,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        case (sel)
            SEL_DATA: rdata = {1'b0, pin_view(cfg.dir, cfg.latch, pin_sync)};
            SEL_DIR:  rdata = {1'b0, cfg.dir};
            SEL_CTRL: rdata = {cfg.fn_io, cfg.pue};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/pio_port7.sv
module pio_port7
    import pio_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SHARED_PIN  = PORT_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rc_mode,
    input  logic              rc_clk,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu
);

    pio_sel_e          sel;
    pio_cfg_t          cfg;
    pio_pad_t          pad;
    logic [PORT_W-1:0] pin_sync;

    assign sel = pio_sel_e'(bus_sel);

    pio_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    pio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    pio_padmux #(.SHARED(SHARED_PIN)) u_padmux (
        .cfg     (cfg),
        .rc_mode (rc_mode),
        .rc_clk  (rc_clk),
        .pad     (pad)
    );

    pio_rdmux u_rdmux (
        .sel      (sel),
        .cfg      (cfg),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    assign pad_oe  = pad.oe;
    assign pad_out = pad.out;
    assign pad_pu  = pad.pu;

    p_clk_pin_r9: assert property (@(posedge clk) disable iff (rst)
        (rc_mode && !bus_rdata[DATA_W-1] && sel == SEL_CTRL)
            |-> (pad_oe[SHARED_PIN] && !pad_pu[SHARED_PIN]));

endmodule

// File: tb/pio_port7_bench.sv
module pio_port7_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_sel = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rc_mode = 1'b0;
    logic       rc_clk = 1'b0;
    logic [6:0] pin_in = '0;
    logic [6:0] pad_oe, pad_out, pad_pu;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pio_port7 u_pio_port7 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rc_mode(rc_mode),
        .rc_clk(rc_clk), .pin_in(pin_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] data);
        bus_sel = sel;
        #1;
        data = bus_rdata;
    endtask

    task automatic check_pads(input string req, input logic [6:0] dir, input logic [6:0] lat,
                              input logic [6:0] pue, input logic fn);
        logic [6:0] eo, ev, ep;
        eo = dir; ev = lat; ep = pue & ~dir;
        if (rc_mode && !fn) begin
            eo[6] = 1'b1; ev[6] = rc_clk; ep[6] = 1'b0;
        end
        #1;
        check({req, " oe"},  {1'b0, pad_oe},  {1'b0, eo});
        check({req, " out"}, {1'b0, pad_out}, {1'b0, ev});
        check({req, " pu"},  {1'b0, pad_pu},  {1'b0, ep});
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] r;
        logic [6:0] prev_pin;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(2'd0, r); check("R1 data", r, 8'h00);
        rd(2'd1, r); check("R1 dir", r, 8'h00);
        rd(2'd2, r); check("R1 ctrl", r, 8'h00);
        check("R1 oe", {1'b0, pad_oe}, 8'h00);
        check("R1 pu", {1'b0, pad_pu}, 8'h00);

        // R2: unused select ignored and reads zero
        wr(2'd1, 8'h5A); wr(2'd2, 8'hC3); wr(2'd0, 8'h7F);
        wr(2'd3, 8'hFF);
        rd(2'd3, r); check("R2 sel3 read", r, 8'h00);
        rd(2'd1, r); check("R2 dir kept", r, 8'h5A);
        rd(2'd2, r); check("R2 ctrl kept", r, 8'hC3);
        check("R2 latch kept", {1'b0, pad_out}, 8'h7F);

        // R7 R8 R11 R3 R4: crystal strap, full dir x pue sweep
        rc_mode = 1'b0;
        for (int d = 0; d < 128; d++) begin
            wr(2'd1, {1'b1, 7'(d)});
            wr(2'd0, {1'b0, 7'(d) ^ 7'h55});
            rd(2'd1, r); check("R3 dir readback", r, {1'b0, 7'(d)});
            for (int p = 0; p < 128; p++) begin
                wr(2'd2, {p[0], 7'(p)});
                check_pads("R7 R8 R11 crystal", 7'(d), 7'(d) ^ 7'h55, 7'(p), p[0]);
                if (p == 127) begin
                    rd(2'd2, r); check("R4 ctrl readback", r, {1'b1, 7'h7F});
                end
            end
        end

        // R9 R10: RC strap, shared pin in both functions
        rc_mode = 1'b1;
        for (int fn = 0; fn < 2; fn++) begin
            wr(2'd2, {fn[0], 7'h7F});
            for (int d = 0; d < 128; d++) begin
                wr(2'd1, {1'b0, 7'(d)});
                wr(2'd0, {1'b0, ~7'(d)});
                for (int c = 0; c < 2; c++) begin
                    rc_clk = c[0];
                    check_pads(fn == 0 ? "R9 clock pin" : "R10 io pin",
                               7'(d), ~7'(d), 7'h7F, fn[0]);
                end
            end
        end
        rc_clk = 1'b0;
        rc_mode = 1'b0;

        // R5 R6: data read mux, synchroniser lag, latch writes hidden on inputs
        prev_pin = '0;
        pin_in = '0;
        repeat (3) @(negedge clk);
        for (int d = 0; d < 128; d++) begin
            logic [6:0] lat, pin;
            lat = 7'(d * 37);
            pin = 7'(d) ^ 7'h2A;
            wr(2'd1, {1'b0, 7'(d)});
            wr(2'd0, {1'b0, lat});
            pin_in = pin;
            @(negedge clk);
            rd(2'd0, r);
            check("R6 one edge old", r, {1'b0, (7'(d) & lat) | (~7'(d) & prev_pin)});
            @(negedge clk);
            rd(2'd0, r);
            check("R5 R6 two edges", r, {1'b0, (7'(d) & lat) | (~7'(d) & pin)});
            wr(2'd0, {1'b0, ~lat});
            rd(2'd0, r);
            check("R6 latch write hidden", r, {1'b0, (7'(d) & ~lat) | (~7'(d) & pin)});
            prev_pin = pin;
        end

        done = 1;
        finish_run();
    end

endmodule